// File: doc/BRIEF.md
# Tile Signature Write-Skip Unit

This unit sits in front of the frame-buffer writer. The tile renderer streams the final pixels of one tile through a valid/ready handshake and flags the last beat. The unit folds every accepted pixel into a 64-bit CRC signature. When the tile closes, it compares the signature with the one kept for the same screen tile from the previous frame. It then pulses a decision: skip when the two signatures match, write when they differ or when no earlier signature exists. The writer uses that decision to drop or perform the tile's memory write.

The signature table has one entry per tile position, and each entry carries a valid flag. Every decision overwrites the entry with the new signature. A frame-start flush marks all entries empty, so the first tile at each position after a flush is always written. A signature match is trusted without any second check. Two different tiles that share a CRC are therefore skipped, and the frame keeps stale pixels at that position until the tile changes again.

Top module: `tile_skip_unit`

## Requirements
- R1: After reset `dec_valid_o` is 0 and `pix_ready_o` is 1.
- R2: `dec_sig_o` holds the CRC of all beats accepted in the tile, oldest beat first. The CRC uses polynomial 0x42F0E1EBA9EA3693, starts from all zeros, has no reflection and no final XOR, and feeds each 32-bit pixel most significant bit first.
- R3: `dec_valid_o` is high for exactly one cycle, in the cycle after the accepted beat with `pix_last_i` = 1. `dec_idx_o` equals the `tile_idx_i` value sampled on the first accepted beat of that tile.
- R4: A tile whose table entry is empty gets a write decision (`dec_skip_o` = 0).
- R5: A tile whose signature equals the stored signature gets a skip decision (`dec_skip_o` = 1). A different signature gets a write decision.
- R6: Every decision, skip or write, stores the new signature and marks its entry filled.
- R7: A one-cycle `frame_flush_i` empties every entry. A flush in the same cycle as a last beat wins over that tile's table update. That tile's own decision still compares against the contents from before the flush.
- R8: Cycles with `pix_valid_i` low do not change the running signature. Values on `tile_idx_i` after the first beat of a tile have no effect.
- R9: `pix_ready_o` is 0 in the cycle of the decision pulse and 1 in the cycle after it, so the next tile may start there.
- R10: There is no secondary check. Tiles with different pixels but equal signatures produce a skip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_flush_i | input | 1 | Frame start: empties the signature table |
| pix_valid_i | input | 1 | Pixel beat offered |
| pix_ready_o | output | 1 | Unit accepts a beat this cycle |
| pix_data_i | input | PIX_W | Pixel value |
| pix_last_i | input | 1 | Beat is the tile's last |
| tile_idx_i | input | IDX_W | Screen tile position, used on first beat |
| dec_valid_o | output | 1 | One-cycle decision strobe |
| dec_skip_o | output | 1 | 1 = skip the tile's write, 0 = write it |
| dec_idx_o | output | IDX_W | Tile position the decision refers to |
| dec_sig_o | output | SIG_W | Signature computed for the tile |

## Verification
The hardest case to reach from the ports is a signature collision, because a random pair of distinct tiles almost never shares a 64-bit CRC. The stimulus uses the linearity of a zero-seeded CRC: zero pixels placed in front of a tile leave its signature unchanged. A longer tile that starts with zeros therefore collides with the short tile that follows them, and the bench expects a skip. A flush that lands on a last beat is driven on purpose, which checks that the old contents decide the tile and that the flush wins the update.

// File: rtl/tsk_pkg.sv
package tsk_pkg;
    localparam logic [63:0] TSK_POLY_DEF = 64'h42F0_E1EB_A9EA_3693;

    typedef enum logic {
        DEC_WRITE = 1'b0,
        DEC_SKIP  = 1'b1
    } dec_e;
endpackage

// File: rtl/tsk_crc_step.sv
// Folds one data word into a running CRC, most significant bit first.
module tsk_crc_step #(
    parameter int              SIG_W  = 64,
    parameter int              DATA_W = 32,
    parameter logic [SIG_W-1:0] POLY  = tsk_pkg::TSK_POLY_DEF
) (
    input  logic [SIG_W-1:0]  crc_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [SIG_W-1:0]  crc_o
);
    logic [SIG_W-1:0] chain [DATA_W+1];

    assign chain[0] = crc_i;

    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        logic fb;
        assign fb = chain[b][SIG_W-1] ^ data_i[DATA_W-1-b];
        assign chain[b+1] = {chain[b][SIG_W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end

    assign crc_o = chain[DATA_W];
endmodule

// File: rtl/tsk_sig_table.sv
// Per-position signature store with valid flags; flush beats write.
module tsk_sig_table #(
    parameter int ENTRIES = 64,
    parameter int SIG_W   = 64,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush_i,
    input  logic               wr_en_i,
    input  logic [IDX_W-1:0]   wr_idx_i,
    input  logic [SIG_W-1:0]   wr_sig_i,
    input  logic [IDX_W-1:0]   rd_idx_i,
    output logic               rd_valid_o,
    output logic [SIG_W-1:0]   rd_sig_o,
    output logic [ENTRIES-1:0] valid_vec_o
);
    logic [ENTRIES-1:0] valid_d, valid_q;
    logic [SIG_W-1:0]   sig_arr [ENTRIES];
    logic               wr_in_range;
    logic               rd_in_range;

    assign wr_in_range = int'(wr_idx_i) < ENTRIES;
    assign rd_in_range = int'(rd_idx_i) < ENTRIES;

    always_comb begin
        valid_d = valid_q;
        if (wr_en_i && wr_in_range) begin
            valid_d[wr_idx_i] = 1'b1;
        end
        if (flush_i) begin
            valid_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else begin
            valid_q <= valid_d;
        end
    end

    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
        logic [SIG_W-1:0] sig_d, sig_q;

        always_comb begin
            sig_d = sig_q;
            if (wr_en_i && (int'(wr_idx_i) == e)) begin
                sig_d = wr_sig_i;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sig_q <= '0;
            end else begin
                sig_q <= sig_d;
            end
        end

        assign sig_arr[e] = sig_q;
    end

    assign rd_valid_o  = rd_in_range && valid_q[rd_idx_i];
    assign rd_sig_o    = rd_in_range ? sig_arr[rd_idx_i] : '0;
    assign valid_vec_o = valid_q;
endmodule

// File: rtl/tile_skip_unit.sv
module tile_skip_unit #(
    parameter int               ENTRIES = 64,
    parameter int               PIX_W   = 32,
    parameter int               SIG_W   = 64,
    parameter logic [SIG_W-1:0] POLY    = tsk_pkg::TSK_POLY_DEF,
    localparam int              IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_flush_i,
    input  logic             pix_valid_i,
    output logic             pix_ready_o,
    input  logic [PIX_W-1:0] pix_data_i,
    input  logic             pix_last_i,
    input  logic [IDX_W-1:0] tile_idx_i,
    output logic             dec_valid_o,
    output logic             dec_skip_o,
    output logic [IDX_W-1:0] dec_idx_o,
    output logic [SIG_W-1:0] dec_sig_o
);
    import tsk_pkg::*;

    typedef struct packed {
        logic [SIG_W-1:0] crc;
        logic [IDX_W-1:0] idx;
        logic             mid;
        logic             dv;
        dec_e             dec;
        logic [IDX_W-1:0] didx;
        logic [SIG_W-1:0] dsig;
    } st_t;

    st_t st_d, st_q;

    logic             accept;
    logic             close;
    logic [IDX_W-1:0] cur_idx;
    logic [SIG_W-1:0] crc_next;
    logic             old_valid;
    logic [SIG_W-1:0] old_sig;
    logic [ENTRIES-1:0] tab_valid_w;

    assign pix_ready_o = !st_q.dv;
    assign accept      = pix_valid_i && pix_ready_o;
    assign close       = accept && pix_last_i;
    assign cur_idx     = st_q.mid ? st_q.idx : tile_idx_i;

    tsk_crc_step #(
        .SIG_W (SIG_W),
        .DATA_W(PIX_W),
        .POLY  (POLY)
    ) u_crc (
        .crc_i (st_q.crc),
        .data_i(pix_data_i),
        .crc_o (crc_next)
    );

    tsk_sig_table #(
        .ENTRIES(ENTRIES),
        .SIG_W  (SIG_W)
    ) u_tab (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush_i    (frame_flush_i),
        .wr_en_i    (close),
        .wr_idx_i   (cur_idx),
        .wr_sig_i   (crc_next),
        .rd_idx_i   (cur_idx),
        .rd_valid_o (old_valid),
        .rd_sig_o   (old_sig),
        .valid_vec_o(tab_valid_w)
    );

    always_comb begin
        st_d    = st_q;
        st_d.dv = 1'b0;
        if (accept) begin
            if (!st_q.mid) begin
                st_d.idx = tile_idx_i;
            end
            st_d.mid = 1'b1;
            st_d.crc = crc_next;
            if (pix_last_i) begin
                st_d.mid  = 1'b0;
                st_d.crc  = '0;
                st_d.dv   = 1'b1;
                st_d.dec  = (old_valid && (old_sig == crc_next)) ? DEC_SKIP : DEC_WRITE;
                st_d.didx = cur_idx;
                st_d.dsig = crc_next;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{crc: '0, idx: '0, mid: 1'b0, dv: 1'b0, dec: DEC_WRITE,
                      didx: '0, dsig: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign dec_valid_o = st_q.dv;
    assign dec_skip_o  = (st_q.dec == DEC_SKIP);
    assign dec_idx_o   = st_q.didx;
    assign dec_sig_o   = st_q.dsig;
endmodule

// File: rtl/tile_skip_chk.sv
module tile_skip_chk #(
    parameter int  ENTRIES = 64,
    localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               frame_flush_i,
    input logic               pix_valid_i,
    input logic               pix_ready_o,
    input logic               pix_last_i,
    input logic               dec_valid_o,
    input logic [IDX_W-1:0]   dec_idx_o,
    input logic [ENTRIES-1:0] tab_valid
);
    // R3
    dec_follows_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid_i && pix_ready_o && pix_last_i) |=> dec_valid_o);

    // R3
    dec_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid_o |=> !dec_valid_o);

    // R9
    ready_reopens_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid_i && pix_ready_o && pix_last_i) |=> ##1 pix_ready_o);

    // R6
    entry_filled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid_i && pix_ready_o && pix_last_i && !frame_flush_i) |=> tab_valid[dec_idx_o]);

    // R7
    flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_flush_i |=> (tab_valid == '0));
endmodule

bind tile_skip_unit tile_skip_chk #(.ENTRIES(ENTRIES)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_flush_i(frame_flush_i),
    .pix_valid_i  (pix_valid_i),
    .pix_ready_o  (pix_ready_o),
    .pix_last_i   (pix_last_i),
    .dec_valid_o  (dec_valid_o),
    .dec_idx_o    (dec_idx_o),
    .tab_valid    (tab_valid_w)
);

// File: tb/tb_tile_skip_unit.sv
module tb_tile_skip_unit;
    localparam logic [63:0] POLY = 64'h42F0_E1EB_A9EA_3693;

    typedef struct {
        int          idx;
        bit          skip;
        logic [63:0] sig;
        string       req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_flush_i = 1'b0;
    logic        pix_valid_i = 1'b0;
    logic        pix_ready_o;
    logic [31:0] pix_data_i = '0;
    logic        pix_last_i = 1'b0;
    logic [5:0]  tile_idx_i = '0;
    logic        dec_valid_o;
    logic        dec_skip_o;
    logic [5:0]  dec_idx_o;
    logic [63:0] dec_sig_o;

    int   n_chk = 0;
    int   n_bad = 0;
    bit   done = 1'b0;
    exp_t exp_q[$];
    logic [63:0] m_sig [64];
    bit          m_val [64];

    always #2 clk = ~clk;

    tile_skip_unit dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_flush_i(frame_flush_i),
        .pix_valid_i  (pix_valid_i),
        .pix_ready_o  (pix_ready_o),
        .pix_data_i   (pix_data_i),
        .pix_last_i   (pix_last_i),
        .tile_idx_i   (tile_idx_i),
        .dec_valid_o  (dec_valid_o),
        .dec_skip_o   (dec_skip_o),
        .dec_idx_o    (dec_idx_o),
        .dec_sig_o    (dec_sig_o)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] ref_sig(input logic [31:0] px[$]);
        logic [63:0] c = '0;
        foreach (px[i]) begin
            for (int b = 31; b >= 0; b--) begin
                logic top;
                top = c[63] ^ px[i][b];
                c = c << 1;
                if (top) c = c ^ POLY;
            end
        end
        return c;
    endfunction

    // Scoreboard monitor: pops one expectation per decision strobe.
    bit prev_dv = 1'b0;
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (dec_valid_o) begin
                check(!prev_dv, "R3 pulse width", 64'(prev_dv), 64'd0);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R3 unexpected decision", 64'(dec_idx_o), 64'd0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(dec_skip_o == e.skip, e.req, 64'(dec_skip_o), 64'(e.skip));
                    check(dec_sig_o == e.sig, "R2 signature", dec_sig_o, e.sig);
                    check(int'(dec_idx_o) == e.idx, "R3/R8 index", 64'(dec_idx_o), 64'(e.idx));
                end
            end
            prev_dv = dec_valid_o;
        end
    end

    // Driver: predicts the decision, then streams the tile.
    task automatic send_tile(input int idx, input logic [31:0] px[$], input bit stall,
                             input bit flush_on_last, input string req);
        exp_t e;
        e.idx  = idx;
        e.sig  = ref_sig(px);
        e.skip = m_val[idx] && (m_sig[idx] == e.sig);
        e.req  = req;
        exp_q.push_back(e);
        m_sig[idx] = e.sig;
        m_val[idx] = 1'b1;
        if (flush_on_last) begin
            foreach (m_val[k]) m_val[k] = 1'b0;
        end
        foreach (px[i]) begin
            if (stall && ($urandom_range(3) == 0)) begin
                int gap;
                gap = $urandom_range(1, 3);
                for (int g = 0; g < gap; g++) begin
                    @(negedge clk);
                    pix_valid_i = 1'b0;
                    pix_data_i  = $urandom;
                    tile_idx_i  = 6'($urandom);
                end
            end
            @(negedge clk);
            pix_valid_i = 1'b1;
            pix_data_i  = px[i];
            pix_last_i  = (i == px.size() - 1);
            // R8: only the first beat's index counts
            tile_idx_i  = (i == 0) ? 6'(idx) : 6'(idx) ^ 6'($urandom_range(1, 63));
            frame_flush_i = flush_on_last && pix_last_i;
            while (!pix_ready_o) @(negedge clk);
        end
        @(negedge clk);
        pix_valid_i   = 1'b0;
        pix_last_i    = 1'b0;
        frame_flush_i = 1'b0;
        check(dec_valid_o == 1'b1, "R3 strobe after last beat", 64'(dec_valid_o), 64'd1);
        check(pix_ready_o == 1'b0, "R9 ready low in decision cycle", 64'(pix_ready_o), 64'd0);
        @(negedge clk);
        check(pix_ready_o == 1'b1, "R9 ready back after decision", 64'(pix_ready_o), 64'd1);
    endtask

    task automatic flush_table();
        @(negedge clk);
        frame_flush_i = 1'b1;
        @(negedge clk);
        frame_flush_i = 1'b0;
        foreach (m_val[k]) m_val[k] = 1'b0;
    endtask

    initial begin
        logic [31:0] a[$];
        logic [31:0] b[$];
        logic [31:0] ramp[$];
        logic [31:0] col_s[$];
        logic [31:0] col_l[$];
        logic [31:0] one[$];
        foreach (m_val[k]) begin
            m_val[k] = 1'b0;
            m_sig[k] = '0;
        end
        for (int i = 0; i < 16; i++) a.push_back(32'hA5A5_0000 + 32'(i * 7));
        for (int i = 0; i < 16; i++) b.push_back(32'h1234_5678 ^ 32'(i << 3));
        for (int i = 0; i < 256; i++) ramp.push_back(32'(i) * 32'h0101_0101);
        col_s = '{32'hDEAD_BEEF, 32'h0BAD_F00D};
        col_l = '{32'h0, 32'h0, 32'h0, 32'hDEAD_BEEF, 32'h0BAD_F00D};
        one   = '{32'hCAFE_0001};

        repeat (4) @(negedge clk);
        // R1
        check(dec_valid_o == 1'b0, "R1 no strobe in reset", 64'(dec_valid_o), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(dec_valid_o == 1'b0, "R1 no strobe after reset", 64'(dec_valid_o), 64'd0);
        check(pix_ready_o == 1'b1, "R1 ready after reset", 64'(pix_ready_o), 64'd1);

        send_tile(5, a, 1'b0, 1'b0, "R4 empty entry writes");
        send_tile(5, a, 1'b1, 1'b0, "R5/R8 match skips despite stalls");
        send_tile(5, b, 1'b0, 1'b0, "R5 differing tile writes");
        send_tile(5, b, 1'b1, 1'b0, "R6 written tile stored, now skips");
        send_tile(7, ramp, 1'b1, 1'b0, "R4 full tile first time writes");
        send_tile(7, ramp, 1'b0, 1'b0, "R5 full tile repeat skips");
        send_tile(63, a, 1'b0, 1'b0, "R4 top position writes");
        send_tile(63, a, 1'b0, 1'b0, "R6 top position skips");
        flush_table();
        send_tile(5, b, 1'b0, 1'b0, "R7 flushed entry writes");
        send_tile(7, ramp, 1'b1, 1'b0, "R7 flushed full tile writes");
        send_tile(9, a, 1'b0, 1'b0, "R4 position 9 writes");
        send_tile(9, a, 1'b0, 1'b1, "R7 flush on last still compares old");
        send_tile(9, a, 1'b0, 1'b0, "R7 flush beat the update");
        send_tile(3, col_s, 1'b0, 1'b0, "R4 short tile writes");
        send_tile(3, col_l, 1'b1, 1'b0, "R10 colliding tile is skipped");
        send_tile(0, one, 1'b0, 1'b0, "R4 single-beat tile writes");
        send_tile(0, one, 1'b0, 1'b0, "R5 single-beat tile skips");

        repeat (5) @(negedge clk);
        check(exp_q.size() == 0, "R3 all decisions seen", 64'(exp_q.size()), 64'd0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule